// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register with Clock Inhibit

This block is an eight-stage shift register that takes a whole byte at once and sends it out one bit at a time. It can also work as a serial-in, serial-out delay line, because a serial input feeds the stage farthest from the output. A low level on the load control copies the parallel word into the stages. While that level is held, the serial output already shows the top parallel bit, with no edge needed. With load released, each rising edge of the shift clock moves the word one stage toward the output.

The shift clock and a clock-inhibit input are combined by a logical OR, and only a rising edge of that combination advances the register. The design runs entirely on one system clock. It samples the shift clock, the inhibit and the load control, and turns rising edges of the combined clock into single-cycle shift events. It is therefore one synchronous block that fits into a larger chip. The serial output is also given in inverted form.

Top module: `pls_shift_reg`

## Requirements
- R1: While rst_n is low and for the first sample after release, all stages are 0, so ser_out is 0 and ser_out_n is 1 while load_n is high.
- R2: While load_n is low, ser_out equals par_in[WIDTH-1] in the same cycle, before any clk edge, and ser_out_n is its inverse.
- R3: At every clk edge with load_n low, every stage i takes par_in[i] and no shift happens. After load_n returns high, ser_out shows the last loaded par_in[WIDTH-1].
- R4: With load_n high, a sampled rising edge of (shift_clk OR clk_inhibit) moves stage i into stage i+1 and ser_in into stage 0, all within one clk edge.
- R5: After loading byte D and then giving rising shift_clk edges with clk_inhibit low, ser_out shows D[7], D[6], down to D[0], one bit per edge. It then shows the ser_in bits in the order they were taken.
- R6: While clk_inhibit is held high, rising edges of shift_clk do not change the stages.
- R7: While shift_clk is high, clk_inhibit rising or falling does not shift.
- R8: With shift_clk low, a rising edge of clk_inhibit is a rising edge of the combined clock, and it shifts once.
- R9: ser_out_n is always the inverse of ser_out.
- R10: If the combined clock is already high when reset is released, that first high level is not taken as an edge.
- R11: With load_n high and no rising edge of the combined clock, the stages hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and state changes use its rising edge |
| rst_n | input | 1 | Active-low reset; clears the stages |
| shift_clk | input | 1 | Shift clock, sampled by clk |
| clk_inhibit | input | 1 | High blocks shift_clk edges; ORed with shift_clk |
| load_n | input | 1 | Low loads par_in as a level; high allows shifting |
| par_in | input | WIDTH | Parallel word; bit WIDTH-1 is the stage next to the output |
| ser_in | input | 1 | Serial data taken into stage 0 on each shift |
| ser_out | output | 1 | Serial output from the last stage, or par_in[WIDTH-1] during load |
| ser_out_n | output | 1 | Inverse of ser_out |

## Verification
The hardest cases to reach are the ones where the inhibit changes while the shift clock is already high, or rises while the shift clock is low. In these cases the result depends only on the level of the other input, not on the input that moved. Directed sequences load a byte with a 1 only in the top bit and then set up each ordering. A wrong shift then turns ser_out from 1 to 0 at once. Random stimulus changes both inputs independently in every cycle, so the same orderings also come up many times against the bench model. A mid-run reset with the shift clock held high, followed by exactly seven real edges, exposes any spurious first-cycle shift.

// File: rtl/pls_pkg.sv
package pls_pkg;

  localparam int unsigned PLS_WIDTH_DEFAULT = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } stage_act_e;

  // combined shift clock: inhibit high forces the line high, masking edges
  function automatic logic gate_clock(input logic sclk, input logic inhibit);
    return sclk | inhibit;
  endfunction

  // rising edge of a sampled level against its previous sample
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // load outranks shift; shift needs an edge
  function automatic stage_act_e pick_action(input logic load_act, input logic shift_evt);
    stage_act_e act;
    if (load_act)       act = ACT_LOAD;
    else if (shift_evt) act = ACT_SHIFT;
    else                act = ACT_HOLD;
    return act;
  endfunction

  // output tap: during load the parallel top bit passes straight through
  function automatic logic tap_select(input logic load_act, input logic par_top,
                                      input logic stage_top);
    return load_act ? par_top : stage_top;
  endfunction

endpackage

// File: rtl/pls_edge_gate.sv
module pls_edge_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_clk,
  input  logic clk_inhibit,
  output logic gated_clk,
  output logic shift_rise
);
  import pls_pkg::*;

  logic prev_q;

  assign gated_clk  = gate_clock(shift_clk, clk_inhibit);
  assign shift_rise = rise_of(gated_clk, prev_q);

  // reset to 1 so a line already high at release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= gated_clk;
  end

endmodule

// File: rtl/pls_stage_chain.sv
module pls_stage_chain #(
  parameter int unsigned WIDTH = pls_pkg::PLS_WIDTH_DEFAULT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pls_pkg::stage_act_e    action,
  input  logic [WIDTH-1:0]       par_in,
  input  logic                   ser_in,
  output logic [WIDTH-1:0]       stage_q
);
  import pls_pkg::*;

  logic [WIDTH-1:0] feed;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign feed[gi] = ser_in;
      end else begin : g_body
        assign feed[gi] = stage_q[gi-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[gi] <= 1'b0;
        end else begin
          case (action)
            ACT_LOAD:  stage_q[gi] <= par_in[gi];
            ACT_SHIFT: stage_q[gi] <= feed[gi];
            default:   stage_q[gi] <= stage_q[gi];
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pls_out_stage.sv
module pls_out_stage (
  input  logic load_act,
  input  logic par_top,
  input  logic stage_top,
  output logic ser_out,
  output logic ser_out_n
);
  import pls_pkg::*;

  logic tap;

  assign tap       = tap_select(load_act, par_top, stage_top);
  assign ser_out   = tap;
  assign ser_out_n = ~tap;

endmodule

// File: rtl/pls_shift_reg.sv
module pls_shift_reg #(
  parameter int unsigned WIDTH = pls_pkg::PLS_WIDTH_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_clk,
  input  logic             clk_inhibit,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  import pls_pkg::*;

  localparam int unsigned TOP = WIDTH - 1;

  // named internal events for the checker
  logic             gated_clk;
  logic             shift_rise;
  logic             load_act;
  logic             shift_evt;
  stage_act_e       action;
  logic [WIDTH-1:0] stage_q;

  assign load_act  = ~load_n;

  pls_edge_gate i_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_clk   (shift_clk),
    .clk_inhibit (clk_inhibit),
    .gated_clk   (gated_clk),
    .shift_rise  (shift_rise)
  );

  assign action    = pick_action(load_act, shift_rise);
  assign shift_evt = (action == ACT_SHIFT);

  pls_stage_chain #(.WIDTH(WIDTH)) i_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .action  (action),
    .par_in  (par_in),
    .ser_in  (ser_in),
    .stage_q (stage_q)
  );

  pls_out_stage i_out (
    .load_act  (load_act),
    .par_top   (par_in[TOP]),
    .stage_top (stage_q[TOP]),
    .ser_out   (ser_out),
    .ser_out_n (ser_out_n)
  );

endmodule

// File: rtl/pls_shift_checker.sv
module pls_shift_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_clk,
  input logic             clk_inhibit,
  input logic             load_n,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input logic             ser_out,
  input logic             ser_out_n,
  input logic [WIDTH-1:0] stage_q,
  input logic             shift_evt
);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> stage_q == $past(par_in)); // R3

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && shift_evt) |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !shift_evt) |=> $stable(stage_q)); // R11

  AST_INHIBIT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_inhibit && $past(clk_inhibit)) |-> !shift_evt); // R6

  AST_HIGH_CLOCK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_clk && $past(shift_clk)) |-> !shift_evt); // R7

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> ser_out == par_in[WIDTH-1]); // R2

  AST_OUT_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out_n != ser_out); // R9

endmodule

bind pls_shift_reg pls_shift_checker #(.WIDTH(WIDTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shift_clk   (shift_clk),
  .clk_inhibit (clk_inhibit),
  .load_n      (load_n),
  .par_in      (par_in),
  .ser_in      (ser_in),
  .ser_out     (ser_out),
  .ser_out_n   (ser_out_n),
  .stage_q     (stage_q),
  .shift_evt   (shift_evt)
);

// File: tb/test_pls_shift_reg.sv
module test_pls_shift_reg;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       shift_clk;
  logic       clk_inhibit;
  logic       load_n;
  logic [7:0] par_in;
  logic       ser_in;
  logic       ser_out;
  logic       ser_out_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model
  logic [7:0] m_reg;
  logic       m_prev;

  always #4 clk = ~clk;

  pls_shift_reg #(.WIDTH(8)) i_pls_shift_reg (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .clk_inhibit(clk_inhibit),
    .load_n(load_n), .par_in(par_in), .ser_in(ser_in),
    .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  function automatic logic b_line(input logic s, input logic inh);
    return (s === 1'b1) || (inh === 1'b1);
  endfunction

  function automatic logic [7:0] b_next(input logic [7:0] cur, input logic ldn,
                                        input logic [7:0] d, input logic edge_seen,
                                        input logic s);
    if (!ldn)      return d;
    if (edge_seen) return {cur[6:0], s};
    return cur;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_reg  = 8'h00;
    m_prev = 1'b1;
  endtask

  // drive one cycle at negedge, check after the following posedge
  task automatic step(input string tag, input logic s, input logic inh,
                      input logic ldn, input logic [7:0] d, input logic sb);
    logic g;
    @(negedge clk);
    shift_clk = s; clk_inhibit = inh; load_n = ldn; par_in = d; ser_in = sb;
    #1;
    if (!ldn) chk("R2 load passes before edge", ser_out, d[7]);
    @(posedge clk);
    #1;
    g      = b_line(s, inh);
    m_reg  = b_next(m_reg, ldn, d, g && !m_prev, sb);
    m_prev = g;
    chk(tag, ser_out, ldn ? m_reg[7] : d[7]);
    chk("R9 inverse", ser_out_n, ~ser_out);
  endtask

  task automatic do_reset(input logic s, input logic inh);
    @(negedge clk);
    rst_n = 1'b0; shift_clk = s; clk_inhibit = inh; load_n = 1'b1; ser_in = 1'b0;
    par_in = 8'h00;
    model_reset();
    @(negedge clk);
    chk("R1 reset ser_out", ser_out, 1'b0);
    chk("R1 reset ser_out_n", ser_out_n, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic load_byte(input logic [7:0] d, input logic s, input logic inh);
    step("R3 load", s, inh, 1'b0, d, 1'b0);
    step("R3 load held", s, inh, 1'b0, d, 1'b0);
    step("R3 after release", s, inh, 1'b1, 8'h00, 1'b0);
    chk("R3 released shows top bit", ser_out, d[7]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] sb;
    rst_n = 1'b0; shift_clk = 1'b0; clk_inhibit = 1'b0; load_n = 1'b1;
    par_in = 8'h00; ser_in = 1'b0;
    model_reset();
    void'($urandom(32'd20240613));
    repeat (2) @(posedge clk);
    do_reset(1'b0, 1'b0);
    step("R1 first sample", 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);

    // R5: ordered serial stream
    d  = 8'hA5;
    sb = 4'b1101;
    load_byte(d, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) begin
      chk("R5 order", ser_out, (k < 8) ? d[7-k] : sb[k-8]);
      step("R4 rise", 1'b1, 1'b0, 1'b1, 8'h00, (k < 4) ? sb[k] : 1'b0);
      step("R11 low half", 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
    end

    // R6: inhibit high blocks shift_clk edges
    load_byte(8'h80, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      step("R6 blocked", 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
      step("R6 blocked", 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    end
    chk("R6 held", ser_out, 1'b1);

    // R7: inhibit moves while shift_clk high
    load_byte(8'h80, 1'b1, 1'b0);
    step("R7 clk high", 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    step("R7 inh rises", 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
    step("R7 inh falls", 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    chk("R7 no shift", ser_out, 1'b1);

    // R8: inhibit rise with shift_clk low shifts once
    load_byte(8'h80, 1'b0, 1'b0);
    step("R8 inh rises", 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    chk("R8 one shift", ser_out, 1'b0);

    // R10: combined clock high at reset release
    do_reset(1'b1, 1'b0);
    step("R10 high at release", 1'b1, 1'b0, 1'b1, 8'h00, 1'b1);
    step("R10 low", 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
    for (int k = 0; k < 7; k++) begin
      step("R10 rise", 1'b1, 1'b0, 1'b1, 8'h00, 1'b1);
      step("R10 low", 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
    end
    chk("R10 seven ones only", ser_out, 1'b0);
    step("R10 eighth rise", 1'b1, 1'b0, 1'b1, 8'h00, 1'b1);
    chk("R10 eighth reaches out", ser_out, 1'b1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      step("R4 random", 1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0),
           !($urandom_range(0, 19) == 0), 8'($urandom), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule